// File: doc/BRIEF.md
# Masked Packed Funnel Right Shifter

This unit is a SIMD datapath stage. For every element position it places an element of the high source above the matching element of the low source. It shifts that double-width pair right logically and keeps the low element-width bits. Element width (16, 32 or 64 bits) and active vector length (128, 256 or 512 bits) are chosen per operation. The shift count is taken from an 8-bit immediate, masked to the element width.

A per-element write mask decides which lanes take the shifted value. Each unmasked lane is either cleared or keeps the previous destination value, selected by a zeroing flag. For 32- and 64-bit elements a broadcast flag makes every lane use element 0 of the high source. All result bits above the active length are forced to zero. Operands are captured when `in_valid` is high, and the result is presented one clock later with `out_valid`. No status flags are produced.

Top module: `vec_funnel_shr`

## Requirements
- R1: For lane j, the result is the low EW bits of ({hi_j, lo_j} >> count), where hi_j is lane j of `src_hi`, lo_j is lane j of `src_lo`, and lane j occupies bits [j*EW +: EW].
- R2: The count is `imm` ANDed with EW-1: 15 for 16-bit, 31 for 32-bit and 63 for 64-bit elements. Higher immediate bits have no effect.
- R3: `ew_sel` 0/1/2 selects 16/32/64-bit elements, and code 3 acts as 64. `vl_sel` 0/1/2 selects 128/256/512 bits, and code 3 acts as 512. The active lane count is the length divided by EW.
- R4: An active lane takes the shifted value when `mask_en` is 0, or when its `wmask` bit j is 1.
- R5: An active lane whose mask bit is 0 while `mask_en` is 1 is written with zero when `zero_mode` is 1.
- R6: Under the same masking condition with `zero_mode` 0, the lane keeps lane j of `old_dst`.
- R7: Every result bit at or above the active length is 0, whatever the mask, mode and `old_dst`.
- R8: When `bcast` is 1 and the elements are 32 or 64 bits wide, every lane uses lane 0 of `src_hi` as its upper half. With 16-bit elements, `bcast` has no effect.
- R9: A count of zero returns lo_j unchanged.
- R10: `wmask` bits at or above the active lane count have no effect on the result.
- R11: `out_valid` is `in_valid` delayed by one clock. `result` changes only in the clock after an accepted input and holds otherwise.
- R12: A synchronous active-high `rst` clears `out_valid` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid; captured this edge |
| src_lo | input | 512 | Low-half operand vector |
| src_hi | input | 512 | High-half operand vector |
| old_dst | input | 512 | Previous destination value for merging |
| imm | input | 8 | Shift immediate |
| wmask | input | 32 | Per-lane write mask |
| mask_en | input | 1 | 1 = apply `wmask` |
| zero_mode | input | 1 | 1 = zero unmasked lanes, 0 = merge |
| bcast | input | 1 | Use lane 0 of `src_hi` for all lanes (32/64-bit only) |
| ew_sel | input | 2 | Element width code |
| vl_sel | input | 2 | Active vector length code |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Registered result vector |

## Verification
Masking and length truncation can apply to the same lane in the same cycle. A lane beyond the active length may have its mask bit set, or may be unmasked in merge mode with a nonzero `old_dst`, and it must still read zero. The random mix drives full-width `wmask`, `old_dst` and nonzero operands together with short lengths, so the two rules collide often. The same collision happens between broadcast and merging. A bench reference model computes every lane from the requirements and compares the full 512-bit vector.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int unsigned NUM_WIDTHS = 3;
   localparam int unsigned BASE_EW    = 16;

   typedef enum logic [1:0] {
      EW_16  = 2'd0,
      EW_32  = 2'd1,
      EW_64  = 2'd2,
      EW_RSV = 2'd3
   } ew_code_e;

   typedef enum logic [1:0] {
      VL_Q   = 2'd0,
      VL_H   = 2'd1,
      VL_F   = 2'd2,
      VL_RSV = 2'd3
   } vl_code_e;

   function automatic logic [1:0] ew_index(input logic [1:0] code);
      return (code == EW_RSV) ? 2'd2 : code;
   endfunction

   function automatic logic [1:0] vl_index(input logic [1:0] code);
      return (code == VL_RSV) ? 2'd2 : code;
   endfunction
endpackage

// File: rtl/fsr_lane.sv
module fsr_lane #(
   parameter int unsigned EW = 16
) (
   input  logic [EW-1:0] lo,
   input  logic [EW-1:0] hi,
   input  logic [EW-1:0] old,
   input  logic [7:0]    cnt,
   input  logic          wr_en,
   input  logic          zero_mode,
   input  logic          active,
   output logic [EW-1:0] res
);
   logic [2*EW-1:0] pair;
   logic [EW-1:0]   funnel;

   assign pair   = {hi, lo};
   assign funnel = EW'(pair >> cnt);

   always_comb begin
      if (!active)        res = '0;
      else if (wr_en)     res = funnel;
      else if (zero_mode) res = '0;
      else                res = old;
   end
endmodule

// File: rtl/fsr_width_unit.sv
module fsr_width_unit #(
   parameter int unsigned VEC_W = 512,
   parameter int unsigned EW    = 16,
   localparam int unsigned LANES = VEC_W / EW
) (
   input  logic [VEC_W-1:0] src_lo,
   input  logic [VEC_W-1:0] src_hi,
   input  logic [VEC_W-1:0] old_dst,
   input  logic [7:0]       imm,
   input  logic [LANES-1:0] wmask,
   input  logic             mask_en,
   input  logic             zero_mode,
   input  logic             bcast,
   input  logic [1:0]       vl_idx,
   output logic [VEC_W-1:0] vec_out
);
   logic [7:0]        cnt;
   logic [VEC_W:0]    len_bits;

   assign cnt      = imm & 8'(EW - 1);
   assign len_bits = (VEC_W + 1)'(VEC_W) >> (2'd2 - vl_idx);

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [EW-1:0] hi_sel;
      logic          act;
      logic          wr;

      assign hi_sel = bcast ? src_hi[EW-1:0] : src_hi[j*EW +: EW];
      assign act    = ((VEC_W + 1)'((j + 1) * EW) <= len_bits);
      assign wr     = !mask_en || wmask[j];

      fsr_lane #(.EW(EW)) u_lane (
         .lo        (src_lo[j*EW +: EW]),
         .hi        (hi_sel),
         .old       (old_dst[j*EW +: EW]),
         .cnt       (cnt),
         .wr_en     (wr),
         .zero_mode (zero_mode),
         .active    (act),
         .res       (vec_out[j*EW +: EW])
      );
   end
endmodule

// File: rtl/vec_funnel_shr.sv
module vec_funnel_shr
   import fsr_pkg::*;
#(
   parameter int unsigned VEC_W = 512,
   localparam int unsigned MASK_W = VEC_W / BASE_EW
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [VEC_W-1:0]  src_lo,
   input  logic [VEC_W-1:0]  src_hi,
   input  logic [VEC_W-1:0]  old_dst,
   input  logic [7:0]        imm,
   input  logic [MASK_W-1:0] wmask,
   input  logic              mask_en,
   input  logic              zero_mode,
   input  logic              bcast,
   input  logic [1:0]        ew_sel,
   input  logic [1:0]        vl_sel,
   output logic              out_valid,
   output logic [VEC_W-1:0]  result
);
   if (VEC_W % 256 != 0 || VEC_W < 256) begin : g_bad_width
      $error("vec_funnel_shr: VEC_W must be a nonzero multiple of 256");
   end

   logic [1:0]       ew_idx;
   logic [1:0]       vl_idx;
   logic             bcast_ok;
   logic [VEC_W-1:0] unit_out [NUM_WIDTHS];
   logic [VEC_W-1:0] next_res;

   assign ew_idx   = ew_index(ew_sel);
   assign vl_idx   = vl_index(vl_sel);
   assign bcast_ok = bcast && (ew_idx != 2'd0);

   for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
      localparam int unsigned EW    = BASE_EW << g;
      localparam int unsigned LANES = VEC_W / EW;
      fsr_width_unit #(.VEC_W(VEC_W), .EW(EW)) u_unit (
         .src_lo    (src_lo),
         .src_hi    (src_hi),
         .old_dst   (old_dst),
         .imm       (imm),
         .wmask     (wmask[LANES-1:0]),
         .mask_en   (mask_en),
         .zero_mode (zero_mode),
         .bcast     (bcast_ok),
         .vl_idx    (vl_idx),
         .vec_out   (unit_out[g])
      );
   end

   assign next_res = unit_out[ew_idx];

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= next_res;
      end
   end

   assert_valid_follow_R11: assert property (@(posedge clk) disable iff (rst)
      out_valid == $past(in_valid));

   assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result));

   assert_reset_clear_R12: assert property (@(posedge clk)
      rst |=> (!out_valid && result == '0));

   assert_above_len_R7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(vl_sel) == 2'd0) |-> (result[VEC_W-1:VEC_W/4] == '0));

   assert_merge_keep_R6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(mask_en && !wmask[0] && !zero_mode && ew_sel == 2'd0))
      |-> (result[15:0] == $past(old_dst[15:0])));

   assert_zero_mode_R5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(mask_en && !wmask[0] && zero_mode))
      |-> (result[15:0] == 16'd0));
endmodule

// File: tb/vec_funnel_shr_tb.sv
module vec_funnel_shr_tb;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [511:0] src_lo, src_hi, old_dst;
   logic [7:0]   imm;
   logic [31:0]  wmask;
   logic         mask_en, zero_mode, bcast;
   logic [1:0]   ew_sel, vl_sel;
   logic         out_valid;
   logic [511:0] result;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_funnel_shr u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .src_lo(src_lo), .src_hi(src_hi), .old_dst(old_dst),
      .imm(imm), .wmask(wmask), .mask_en(mask_en), .zero_mode(zero_mode),
      .bcast(bcast), .ew_sel(ew_sel), .vl_sel(vl_sel),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic [511:0] ref_fn(
      input logic [511:0] lo_v, hi_v, od_v, input logic [7:0] im,
      input logic [31:0] mk, input logic men, zm, bc, input logic [1:0] ec, vc);
      int ew, n, cnt;
      logic [127:0] emask, pair, hi, lo, od, r;
      logic [511:0] acc;
      ew    = 16 << ((ec == 2'd3) ? 2 : ec);
      n     = (128 << ((vc == 2'd3) ? 2 : vc)) / ew;
      cnt   = int'(im) % ew;
      emask = (128'h1 << ew) - 128'h1;
      acc   = '0;
      for (int j = 0; j < 512 / ew; j++) begin
         lo = 128'(lo_v >> (j * ew)) & emask;
         od = 128'(od_v >> (j * ew)) & emask;
         if (bc && ew > 16) hi = 128'(hi_v) & emask;
         else               hi = 128'(hi_v >> (j * ew)) & emask;
         pair = (hi << ew) | lo;
         if (j >= n)                  r = '0;
         else if (!men || mk[j])      r = (pair >> cnt) & emask;
         else if (zm)                 r = '0;
         else                         r = od;
         acc = acc | (512'(r) << (j * ew));
      end
      return acc;
   endfunction

   function automatic logic [511:0] rnd512();
      logic [511:0] v;
      for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom();
      return v;
   endfunction

   task automatic check_vec(input string tag, input logic [511:0] exp);
      checks++;
      if (!out_valid || result !== exp) begin
         errors++;
         $display("FAIL %s: out_valid=%0b result=%h expected valid=1 result=%h",
                  tag, out_valid, result, exp);
      end
   endtask

   task automatic issue(input string tag);
      logic [511:0] exp;
      exp = ref_fn(src_lo, src_hi, old_dst, imm, wmask, mask_en, zero_mode,
                   bcast, ew_sel, vl_sel);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check_vec(tag, exp);
   endtask

   task automatic set_ops(input logic [1:0] ec, vc, input logic [7:0] im,
                          input logic men, zm, bc, input logic [31:0] mk);
      src_lo = rnd512(); src_hi = rnd512(); old_dst = rnd512();
      ew_sel = ec; vl_sel = vc; imm = im; mask_en = men; zero_mode = zm;
      bcast = bc; wmask = mk;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [511:0] held, exp_a, lo_keep;
      void'($urandom(32'd12345));
      rst = 1'b1; in_valid = 1'b0;
      set_ops(2'd0, 2'd2, 8'd0, 1'b0, 1'b0, 1'b0, 32'd0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12: reset state
      checks++;
      if (out_valid !== 1'b0 || result !== '0) begin
         errors++;
         $display("FAIL R12: out_valid=%0b result=%h expected 0/0", out_valid, result);
      end
      rst = 1'b0;

      // R9: zero count returns low source
      set_ops(2'd0, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 32'd0);
      lo_keep = src_lo;
      in_valid = 1'b1; @(posedge clk); @(negedge clk); in_valid = 1'b0;
      check_vec("R9", lo_keep);

      // R2: upper immediate bits ignored (0xF3 behaves as 3 for 16-bit)
      set_ops(2'd0, 2'd2, 8'h03, 1'b0, 1'b0, 1'b0, 32'd0);
      exp_a = ref_fn(src_lo, src_hi, old_dst, 8'h03, wmask, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2);
      imm = 8'hF3;
      in_valid = 1'b1; @(posedge clk); @(negedge clk); in_valid = 1'b0;
      check_vec("R2", exp_a);

      // R1 / R3: each width at full length, large count
      set_ops(2'd1, 2'd2, 8'd29, 1'b0, 1'b0, 1'b0, 32'd0); issue("R1 ew32");
      set_ops(2'd2, 2'd2, 8'd61, 1'b0, 1'b0, 1'b0, 32'd0); issue("R1 ew64");
      set_ops(2'd3, 2'd3, 8'd7,  1'b0, 1'b0, 1'b0, 32'd0); issue("R3 reserved codes");

      // R4: mask disabled writes all; R5 / R6 masked
      set_ops(2'd0, 2'd2, 8'd5, 1'b0, 1'b0, 1'b0, 32'h0); issue("R4");
      set_ops(2'd0, 2'd2, 8'd5, 1'b1, 1'b1, 1'b0, 32'hA5A5_0F0F); issue("R5");
      set_ops(2'd1, 2'd2, 8'd9, 1'b1, 1'b0, 1'b0, 32'h0000_3C96); issue("R6");

      // R7: short length with full mask in merge mode
      set_ops(2'd0, 2'd0, 8'd4, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF); issue("R7 vl128");
      set_ops(2'd2, 2'd1, 8'd33, 1'b1, 1'b0, 1'b0, 32'h0000_0005); issue("R7 vl256");

      // R8: broadcast for 32/64, ignored for 16
      set_ops(2'd1, 2'd2, 8'd12, 1'b0, 1'b0, 1'b1, 32'd0); issue("R8 ew32");
      set_ops(2'd2, 2'd1, 8'd40, 1'b1, 1'b0, 1'b1, 32'h0000_000B); issue("R8 ew64");
      set_ops(2'd0, 2'd2, 8'd6, 1'b0, 1'b0, 1'b0, 32'd0);
      exp_a = ref_fn(src_lo, src_hi, old_dst, imm, wmask, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2);
      bcast = 1'b1;
      in_valid = 1'b1; @(posedge clk); @(negedge clk); in_valid = 1'b0;
      check_vec("R8 ew16 ignored", exp_a);

      // R10: mask bits beyond lane count ignored (2 lanes at ew64/vl128)
      set_ops(2'd2, 2'd0, 8'd17, 1'b1, 1'b0, 1'b0, 32'h0000_0001);
      exp_a = ref_fn(src_lo, src_hi, old_dst, imm, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 2'd2, 2'd0);
      wmask = 32'hFFFF_FFFD;
      in_valid = 1'b1; @(posedge clk); @(negedge clk); in_valid = 1'b0;
      check_vec("R10", exp_a);

      // R11: output holds and valid drops with no input
      held = result;
      src_lo = rnd512(); src_hi = rnd512();
      @(posedge clk); @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || result !== held) begin
         errors++;
         $display("FAIL R11: out_valid=%0b result=%h expected 0 / %h", out_valid, result, held);
      end

      // Random mix: masking, lengths and broadcast colliding (R1 R3 R4 R7)
      for (int i = 0; i < 400; i++) begin
         set_ops(2'($urandom()), 2'($urandom()), 8'($urandom()), 1'($urandom()),
                 1'($urandom()), 1'($urandom()), $urandom());
         issue("R1 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule